// File: doc/BRIEF.md
# Bus Break Condition Unit

This block watches the completed cycles of a CPU bus and decides, for each of two debug channels (C and D), whether a break condition has been met. Each channel compares the operand size of the cycle with a size selector set by software. On a match the channel records the event in sticky status flags. One flag covers instruction fetches and one covers data accesses. The channel can then request a break exception and can start a pulse on an external trigger pin.

Software controls the unit through a small 32-bit register bus. One control/status word holds the flags, the trigger enables, the trigger width code and the per-channel break timing bits. Each channel also has its own size-selector word. The flags can only be cleared by writing zero, so software can clear one flag by writing ones to all the others.

A fetch match can raise its break request in the fetch cycle itself (before execution). It can also be held until the CPU signals that the instruction has completed (after execution). Address and data comparison are not part of this block.

Top module: `bus_break_unit`

## Requirements
- R1: A channel matches a completed bus cycle when its 2-bit size selector is 00 (any size) or equals the cycle's `bus_size` code, where 01 means byte, 10 means word and 11 means longword.
- R2: Control word (address 0) flag bits are: bit 15 for a channel C fetch match, bit 14 for a channel C data match, bit 13 for a channel D fetch match and bit 12 for a channel D data match. A flag is set by the clock edge that ends the matching bus cycle, so it reads 1 from the next cycle on, and it stays set.
- R3: Writing 1 to a flag bit leaves that flag unchanged. Writing 0 clears it, so clearing one flag while writing 1 to the others clears only that flag.
- R4: When a hardware match and a software clear of the same flag happen in one cycle, the flag ends up set.
- R5: `brk_req[0]` belongs to channel C and `brk_req[1]` to channel D. A data match raises the channel's request in the same cycle. A fetch match also raises it in the same cycle when the channel's timing bit (bit 6 for C, bit 5 for D) is 0.
- R6: When the timing bit is 1, a fetch match raises no request in its own cycle. The request is held pending and is raised in the cycle in which `insn_done` is high, and it is then released.
- R7: Bit 18 enables the trigger for channel C and bit 19 enables it for channel D. A match on an enabled channel drives `trig_out` high from the next cycle on. A match on a disabled channel produces no pulse.
- R8: Bits 17:16 give the trigger width: codes 00, 01, 10 and 11 give 1, 2, 4 and 8 cycles high.
- R9: A new enabled match during an active pulse restarts the full width from the cycle after that match.
- R10: While `bus_valid` is low, no flag is set, no data or fetch request is raised and no trigger pulse starts.
- R11: Control word bits 31:20, 11:7 and 4:0 read 0 and ignore writes. Addresses 1 (channel C) and 2 (channel D) hold the size selector in bits 1:0, with the other bits reading 0. Address 3 reads 0.
- R12: After reset every register field, every flag, `brk_req` and `trig_out` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 size C, 2 size D |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | A monitored bus cycle completes this cycle |
| bus_ifetch | input | 1 | The cycle is an instruction fetch (1) or a data access (0) |
| bus_size | input | 2 | Operand size code of the cycle |
| insn_done | input | 1 | Instruction-complete strobe |
| brk_req | output | 2 | Break request per channel (bit 0 C, bit 1 D) |
| trig_out | output | 1 | External trigger pulse |

## Verification
The main sweep tries every pair of channel size selectors against every operand size code, each as a fetch and as a data access. This separates the wildcard code from exact matches, one channel from the other, and fetch flags from data flags. Flag writes are tried with all-ones data, with single-zero patterns, and together with a simultaneous hardware match, which separates a write-one-to-clear design and a clear-wins design from the intended one. Trigger runs cover all four width codes on each channel, a match on a disabled channel, and a second match inside a pulse, so a fixed or extended pulse length shows up as a wrong count. An after-execution run shows whether the request waits for the completion strobe.

// File: rtl/bbu_pkg.sv
package bbu_pkg;
    localparam int NUM_CH    = 2;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int SZ_W      = 2;
    localparam int WCODE_W   = 2;
    localparam int TCNT_W    = (1 << WCODE_W) - 1 + 1;
    localparam int NUM_FLAGS = 2 * NUM_CH;

    // control word bit positions the bench and software rely on
    localparam int TEN_LSB   = 18;
    localparam int WCODE_LSB = 16;
    localparam int FLAG_MSB  = 15;
    localparam int AFTER_MSB = 6;

    localparam logic [ADDR_W-1:0] ADDR_CTRL    = 2'd0;
    localparam int                ADDR_SZ_BASE = 1;

    typedef enum logic [SZ_W-1:0] {
        SZ_ANY  = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LONG = 2'b11
    } size_e;
endpackage

// File: rtl/bbu_regs.sv
module bbu_regs
    import bbu_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic                            reg_wr,
    input  logic [DATA_W-1:0]               reg_wdata,
    output logic [DATA_W-1:0]               reg_rdata,
    input  logic [NUM_FLAGS-1:0]            flags_i,
    output logic [NUM_CH-1:0][SZ_W-1:0]     size_o,
    output logic [NUM_CH-1:0]               after_o,
    output logic [NUM_CH-1:0]               ten_o,
    output logic [WCODE_W-1:0]              wcode_o,
    output logic [NUM_FLAGS-1:0]            clr_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][SZ_W-1:0] size;
        logic [NUM_CH-1:0]           after;
        logic [NUM_CH-1:0]           ten;
        logic [WCODE_W-1:0]          wcode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic ctrl_wr;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);

    always_comb begin
        cfg_d = cfg_q;
        clr_o = '0;
        if (ctrl_wr) begin
            cfg_d.wcode = reg_wdata[WCODE_LSB +: WCODE_W];
            for (int i = 0; i < NUM_CH; i++) begin
                cfg_d.ten[i]     = reg_wdata[TEN_LSB + i];
                cfg_d.after[i]   = reg_wdata[AFTER_MSB - i];
                clr_o[2*i]       = ~reg_wdata[FLAG_MSB - 2*i];
                clr_o[2*i + 1]   = ~reg_wdata[FLAG_MSB - 2*i - 1];
            end
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_wr && (int'(reg_addr) == ADDR_SZ_BASE + i))
                cfg_d.size[i] = reg_wdata[SZ_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata[WCODE_LSB +: WCODE_W] = cfg_q.wcode;
            for (int i = 0; i < NUM_CH; i++) begin
                reg_rdata[TEN_LSB + i]          = cfg_q.ten[i];
                reg_rdata[AFTER_MSB - i]        = cfg_q.after[i];
                reg_rdata[FLAG_MSB - 2*i]       = flags_i[2*i];
                reg_rdata[FLAG_MSB - 2*i - 1]   = flags_i[2*i + 1];
            end
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(reg_addr) == ADDR_SZ_BASE + i)
                reg_rdata[SZ_W-1:0] = cfg_q.size[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign size_o  = cfg_q.size;
    assign after_o = cfg_q.after;
    assign ten_o   = cfg_q.ten;
    assign wcode_o = cfg_q.wcode;

    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[31:20], reg_wdata[11:7], reg_wdata[4:2]};

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_CTRL) |->
            (reg_rdata[31:20] == '0 && reg_rdata[11:7] == '0 && reg_rdata[4:0] == '0));

    // R8
    wcode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (wcode_o == $past(reg_wdata[WCODE_LSB +: WCODE_W])));
endmodule

// File: rtl/bbu_channel.sv
module bbu_channel
    import bbu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SZ_W-1:0]  size_sel,
    input  logic             after_sel,
    input  logic             bus_valid,
    input  logic             bus_ifetch,
    input  logic [SZ_W-1:0]  bus_size,
    input  logic             insn_done,
    input  logic             clr_fetch,
    input  logic             clr_data,
    output logic             flag_fetch_o,
    output logic             flag_data_o,
    output logic             hit_o,
    output logic             brk_o
);
    typedef struct packed {
        logic flag_fetch;
        logic flag_data;
        logic pend;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic hit, fetch_hit, data_hit;

    always_comb begin
        hit       = bus_valid && ((size_sel == SZ_ANY) || (size_sel == bus_size));
        fetch_hit = hit && bus_ifetch;
        data_hit  = hit && !bus_ifetch;

        st_d = st_q;
        // hardware set has priority over a software clear
        st_d.flag_fetch = fetch_hit || (st_q.flag_fetch && !clr_fetch);
        st_d.flag_data  = data_hit  || (st_q.flag_data  && !clr_data);
        if (fetch_hit && after_sel) st_d.pend = 1'b1;
        else if (insn_done)         st_d.pend = 1'b0;

        brk_o = data_hit || (fetch_hit && !after_sel) || (st_q.pend && insn_done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_fetch_o = st_q.flag_fetch;
    assign flag_data_o  = st_q.flag_data;
    assign hit_o        = hit;

    // R2
    flag_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag_fetch) |-> $past(bus_valid && bus_ifetch));

    // R3
    flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag_data) |-> $past(clr_data));

    // R6
    pend_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.pend) |-> $past(insn_done));

    // R10
    idle_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid && !insn_done) |-> !brk_o);
endmodule

// File: rtl/bbu_trigger.sv
module bbu_trigger
    import bbu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [WCODE_W-1:0] wcode,
    output logic               trig_out
);
    typedef struct packed {
        logic [TCNT_W-1:0] cnt;
    } trg_state_t;

    trg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire)                st_d.cnt = TCNT_W'(1) << wcode;
        else if (st_q.cnt != '0) st_d.cnt = st_q.cnt - TCNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig_out = (st_q.cnt != '0);

    // R7
    trig_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> trig_out);

    // R9
    trig_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_out && !fire) |=> !trig_out);
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
    import bbu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        bus_valid,
    input  logic        bus_ifetch,
    input  logic [1:0]  bus_size,
    input  logic        insn_done,
    output logic [1:0]  brk_req,
    output logic        trig_out
);
    logic [NUM_CH-1:0][SZ_W-1:0] size_sel;
    logic [NUM_CH-1:0]           after_sel;
    logic [NUM_CH-1:0]           ten;
    logic [WCODE_W-1:0]          wcode;
    logic [NUM_FLAGS-1:0]        clr;
    logic [NUM_FLAGS-1:0]        flags;
    logic [NUM_CH-1:0]           hit;
    logic                        fire;

    bbu_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .flags_i   (flags),
        .size_o    (size_sel),
        .after_o   (after_sel),
        .ten_o     (ten),
        .wcode_o   (wcode),
        .clr_o     (clr)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        bbu_channel u_ch (
            .clk          (clk),
            .rst_n        (rst_n),
            .size_sel     (size_sel[g]),
            .after_sel    (after_sel[g]),
            .bus_valid    (bus_valid),
            .bus_ifetch   (bus_ifetch),
            .bus_size     (bus_size),
            .insn_done    (insn_done),
            .clr_fetch    (clr[2*g]),
            .clr_data     (clr[2*g + 1]),
            .flag_fetch_o (flags[2*g]),
            .flag_data_o  (flags[2*g + 1]),
            .hit_o        (hit[g]),
            .brk_o        (brk_req[g])
        );
    end

    assign fire = |(hit & ten);

    bbu_trigger u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .wcode    (wcode),
        .trig_out (trig_out)
    );

    // R10
    idle_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid && !trig_out) |=> !trig_out);
endmodule

// File: tb/bus_break_unit_bench.sv
module bus_break_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_valid = 1'b0;
    logic        bus_ifetch = 1'b0;
    logic [1:0]  bus_size = '0;
    logic        insn_done = 1'b0;
    logic [1:0]  brk_req;
    logic        trig_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bus_break_unit u_bus_break_unit (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_ifetch(bus_ifetch), .bus_size(bus_size), .insn_done(insn_done),
        .brk_req(brk_req), .trig_out(trig_out)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic bus_cyc(input logic f, input logic [1:0] sz, output logic [1:0] brk);
        bus_valid = 1'b1; bus_ifetch = f; bus_size = sz;
        #1 brk = brk_req;
        step();
        bus_valid = 1'b0; bus_ifetch = 1'b0; bus_size = '0;
    endtask

    task automatic count_trig(input int cycles, inout int n);
        for (int k = 0; k < cycles; k++) begin
            if (trig_out) n++;
            step();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        logic [1:0]  bk;
        int          tc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), rv);
            chk(rv, 32'h0, "R12 reset register");
        end
        chk({30'b0, brk_req}, 32'h0, "R12 reset brk_req");
        chk({31'b0, trig_out}, 32'h0, "R12 reset trig_out");

        // R1 R2 R5 sweep: size selectors x size code x fetch/data
        for (int sc = 0; sc < 4; sc++)
        for (int sd = 0; sd < 4; sd++)
        for (int sz = 1; sz < 4; sz++)
        for (int f = 0; f < 2; f++) begin
            logic mc, md;
            logic [31:0] expf;
            wr(2'd0, 32'h0);
            wr(2'd1, 32'(sc));
            wr(2'd2, 32'(sd));
            mc = (sc == 0) || (sc == sz);
            md = (sd == 0) || (sd == sz);
            bus_cyc(f[0], 2'(sz), bk);
            chk({30'b0, bk}, {30'b0, md, mc}, "R5 R1 request in match cycle");
            expf = (32'(mc & f[0]) << 15) | (32'(mc & ~f[0]) << 14)
                 | (32'(md & f[0]) << 13) | (32'(md & ~f[0]) << 12);
            rd(2'd0, rv);
            chk(rv, expf, "R2 R1 flag after match");
            step();
            rd(2'd0, rv);
            chk(rv, expf, "R2 flag sticky");
        end

        // R3 write-one ignored, write-zero clears
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0);
        bus_cyc(1'b1, 2'd3, bk);
        bus_cyc(1'b0, 2'd1, bk);
        rd(2'd0, rv);
        chk(rv, 32'h0000F000, "R2 all four flags");
        wr(2'd0, 32'h0000F000);
        rd(2'd0, rv);
        chk(rv, 32'h0000F000, "R3 write ones keeps flags");
        wr(2'd0, 32'h0000B000);
        rd(2'd0, rv);
        chk(rv, 32'h0000B000, "R3 clear C data flag only");
        wr(2'd0, 32'h00007000);
        rd(2'd0, rv);
        chk(rv, 32'h00003000, "R3 clear C fetch flag only");

        // R4 set wins over same-cycle clear
        wr(2'd0, 32'h0);
        reg_addr = 2'd0; reg_wr = 1'b1; reg_wdata = 32'h0;
        bus_valid = 1'b1; bus_ifetch = 1'b1; bus_size = 2'd2;
        step();
        reg_wr = 1'b0; bus_valid = 1'b0; bus_ifetch = 1'b0; bus_size = '0;
        rd(2'd0, rv);
        chk(rv, 32'h0000A000, "R4 hardware set wins");

        // R6 after-execution request on channel C, D stays before-mode
        wr(2'd0, 32'h00000040);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h3);
        bus_cyc(1'b1, 2'd1, bk);
        chk({30'b0, bk}, 32'h0, "R6 no request in fetch cycle");
        step();
        #1 chk({30'b0, brk_req}, 32'h0, "R6 request held");
        insn_done = 1'b1;
        #1 chk({30'b0, brk_req}, 32'h1, "R6 request on insn_done");
        step();
        insn_done = 1'b0;
        #1 chk({30'b0, brk_req}, 32'h0, "R6 request released");
        insn_done = 1'b1;
        #1 chk({30'b0, brk_req}, 32'h0, "R6 no second request");
        step();
        insn_done = 1'b0;

        // R7 R8 widths on each channel
        for (int ch = 0; ch < 2; ch++)
        for (int w = 0; w < 4; w++) begin
            wr(2'd0, (32'h1 << (18 + ch)) | 32'(w << 16));
            wr(2'(1 + ch), 32'h0);
            wr(2'(2 - ch), 32'h3);
            bus_cyc(1'b0, 2'd1, bk);
            #1 chk({31'b0, trig_out}, 32'h1, "R7 pulse starts next cycle");
            tc = 0;
            count_trig(12, tc);
            chk(32'(tc), 32'(1 << w), "R8 pulse width");
        end

        // R7 disabled channel: only D matches, only C enabled
        wr(2'd0, 32'h00070000);
        wr(2'd1, 32'h3);
        wr(2'd2, 32'h0);
        bus_cyc(1'b0, 2'd1, bk);
        tc = 0;
        count_trig(12, tc);
        chk(32'(tc), 32'h0, "R7 disabled channel no pulse");

        // R9 restart during pulse
        wr(2'd0, 32'h00070000);
        wr(2'd1, 32'h0);
        bus_cyc(1'b1, 2'd2, bk);
        tc = 0;
        count_trig(2, tc);
        if (trig_out) tc++;
        bus_cyc(1'b1, 2'd2, bk);
        count_trig(12, tc);
        chk(32'(tc), 32'd11, "R9 restart full width");

        // R10 idle bus
        wr(2'd0, 32'h0);
        wr(2'd0, 32'h000F0000);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0);
        bus_valid = 1'b0; bus_ifetch = 1'b1; bus_size = 2'd3;
        #1 chk({30'b0, brk_req}, 32'h0, "R10 idle no request");
        tc = 0;
        count_trig(5, tc);
        chk(32'(tc), 32'h0, "R10 idle no trigger");
        bus_ifetch = 1'b0; bus_size = '0;
        rd(2'd0, rv);
        chk(rv, 32'h000F0000, "R10 idle no flag");

        // R11 reserved bits
        wr(2'd0, 32'h0);
        wr(2'd0, 32'hFFFFFFFF);
        rd(2'd0, rv);
        chk(rv, 32'h000F0060, "R11 control reserved bits");
        wr(2'd1, 32'hFFFFFFFF);
        rd(2'd1, rv);
        chk(rv, 32'h3, "R11 size C reserved bits");
        wr(2'd2, 32'hFFFFFFFE);
        rd(2'd2, rv);
        chk(rv, 32'h2, "R11 size D reserved bits");
        wr(2'd3, 32'hFFFFFFFF);
        rd(2'd3, rv);
        chk(rv, 32'h0, "R11 address 3 reads zero");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule